// File: doc/BRIEF.md
# Reference Half-Period Delta Encoder

This block measures a slow reference signal against a fast clock domain. The reference arrives asynchronously, so it is brought into the fast domain through a chain of synchronizer flops, and both its rising and falling transitions are found there. At every transition the block reads a free-running fast half-cycle counter supplied from outside. The difference from the previous transition is the number of fast ticks in the reference half-period just ended, held as a 6-bit unsigned delta.

In compressed mode each delta becomes a 4-bit two's-complement deviation from a programmable nominal interval, which is typically 30. Two deviations make one byte per full reference period. In raw mode each delta is sent as its own byte. Bytes leave through a single-entry valid/ready output. A value that does not fit, or a byte the consumer had no room for, sets a sticky flag that a clear strobe resets.

Top module: `edge_delta_enc`

## Requirements
- R1: After reset, outValid, overflowFlag and overrunFlag are all 0.
- R2: Each transition of refIn, rising or falling, ends one sample. The first transition after reset only marks the starting count and produces no sample.
- R3: A sample's delta is the change of fastCount between two consecutive refIn transitions (modulo 2^CNT_W). In raw mode (rawMode=1) each sample gives one byte equal to the delta zero-extended to 8 bits.
- R4: A delta above 63 is clipped to 63 and sets overflowFlag.
- R5: In compressed mode (rawMode=0) a sample's nibble is the 4-bit two's-complement value of delta minus expected.
- R6: A deviation above +7 becomes 7 (0x7) and one below -8 becomes -8 (0x8), and either case sets overflowFlag. The values +7 and -8 themselves do not set it. overflowFlag stays set until cleared.
- R7: In compressed mode, the interval that ends on a falling edge of refIn goes in bits [3:0]. The interval that ends on the next rising edge goes in bits [7:4], and the byte is emitted after that second interval. A rising-ended interval with no low nibble held is discarded. Raw mode discards any held low nibble.
- R8: While outValid=1 and outReady=0, outValid stays 1 and outData does not change.
- R9: A byte completed while outValid=1 and outReady=0 is dropped, and overrunFlag is set and stays set until cleared.
- R10: A one-cycle pulse on clrFlags clears both overflowFlag and overrunFlag, unless a new event sets a flag in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock |
| rstN | input | 1 | Active-low synchronous reset |
| fastCount | input | CNT_W (16) | Free-running fast half-cycle count |
| refIn | input | 1 | Asynchronous reference signal |
| expected | input | DELTA_W (6) | Nominal ticks per reference half-period |
| rawMode | input | 1 | 1 = one raw delta per byte, 0 = packed deviations |
| clrFlags | input | 1 | Strobe that clears both sticky flags |
| outReady | input | 1 | Consumer can accept a byte |
| outData | output | BYTE_W (8) | Output byte |
| outValid | output | 1 | outData holds a byte not yet accepted |
| overflowFlag | output | 1 | Sticky: a delta or deviation was clipped |
| overrunFlag | output | 1 | Sticky: a byte was dropped |

## Verification
The reference is toggled with chosen half-periods. Deviations of 0 and +1 show which nibble sits where. Pairs of -3/+5 and exactly -8/+7 test sign handling and the clip boundary without setting the flag. A pair of -15/+20 must saturate and set overflowFlag, and a changed expected value must shift the results. Raw half-periods of 45, 63 and 70 separate plain pass-through from clipping. A raw-to-compressed switch that leaves a rising-ended interval without a partner checks that the pairing stays tied to the reference phase. Holding outReady low over two periods checks both the held byte and the dropped one.

// File: rtl/edge_delta_pkg.sv
package edge_delta_pkg;

  // Strobes from control to datapath
  typedef struct packed {
    logic captureEn;   // latch fastCount as the new start point
    logic sampleEn;    // register encoded delta / nibble
    logic holdLowEn;   // keep current nibble as the low half
    logic loadRaw;     // load output byte from raw delta
    logic loadPacked;  // load output byte from two nibbles
  } dpCtrl_t;

  // Status from datapath to control
  typedef struct packed {
    logic edgeSeen;    // synchronized reference changed level
    logic edgeFall;    // ... and the change was high to low
    logic deltaClip;   // delta exceeded its field
    logic devClip;     // deviation exceeded the nibble range
  } dpStat_t;

endpackage

// File: rtl/edge_delta_datapath.sv
module edge_delta_datapath
  import edge_delta_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int DELTA_W     = 6,
  parameter int DEV_W       = 4,
  parameter int BYTE_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [CNT_W-1:0]   fastCount,
  input  logic               refIn,
  input  logic [DELTA_W-1:0] expected,
  input  dpCtrl_t            ctrl,
  output dpStat_t            stat,
  output logic [BYTE_W-1:0]  outData
);

  localparam int DELTA_MAX = (1 << DELTA_W) - 1;
  localparam int DEV_MAX   = (1 << (DEV_W - 1)) - 1;
  localparam int DEV_MIN   = -(1 << (DEV_W - 1));
  localparam int DEVX_W    = DELTA_W + 2;
  localparam logic signed [DEVX_W-1:0] DEV_HI = DEVX_W'(DEV_MAX);
  localparam logic signed [DEVX_W-1:0] DEV_LO = DEVX_W'(DEV_MIN);

  // Synchronizer chain, one flop per stage
  logic [SYNC_STAGES-1:0] syncReg;
  genvar g;
  generate
    for (g = 0; g < SYNC_STAGES; g++) begin : gSync
      if (g == 0) begin : gFirst
        always_ff @(posedge clk) begin
          if (!rstN) syncReg[0] <= 1'b0;
          else       syncReg[0] <= refIn;
        end
      end else begin : gNext
        always_ff @(posedge clk) begin
          if (!rstN) syncReg[g] <= 1'b0;
          else       syncReg[g] <= syncReg[g-1];
        end
      end
    end
  endgenerate

  logic refSync;
  logic refPrev;
  assign refSync = syncReg[SYNC_STAGES-1];

  always_ff @(posedge clk) begin
    if (!rstN) refPrev <= 1'b0;
    else       refPrev <= refSync;
  end

  // Interval measurement
  logic [CNT_W-1:0]   lastCount;
  logic [CNT_W-1:0]   deltaFull;
  logic [DELTA_W-1:0] deltaCut;
  logic               deltaOver;

  always_ff @(posedge clk) begin
    if (!rstN)               lastCount <= '0;
    else if (ctrl.captureEn) lastCount <= fastCount;
  end

  assign deltaFull = fastCount - lastCount;
  assign deltaOver = (deltaFull > CNT_W'(DELTA_MAX));
  assign deltaCut  = deltaOver ? DELTA_W'(DELTA_MAX) : deltaFull[DELTA_W-1:0];

  // Deviation from nominal, saturated into a nibble
  logic signed [DEVX_W-1:0] devWide;
  logic                     devHiClip;
  logic                     devLoClip;
  logic [DEV_W-1:0]         devNib;

  assign devWide   = $signed({2'b00, deltaCut}) - $signed({2'b00, expected});
  assign devHiClip = (devWide > DEV_HI);
  assign devLoClip = (devWide < DEV_LO);

  always_comb begin
    if (devHiClip)      devNib = DEV_W'(DEV_MAX);
    else if (devLoClip) devNib = DEV_W'(DEV_MIN);
    else                devNib = devWide[DEV_W-1:0];
  end

  assign stat.edgeSeen  = refSync ^ refPrev;
  assign stat.edgeFall  = refPrev & ~refSync;
  assign stat.deltaClip = deltaOver;
  assign stat.devClip   = devHiClip | devLoClip;

  // Sample stage and packing
  logic [DELTA_W-1:0] sampleDelta;
  logic [DEV_W-1:0]   sampleNib;
  logic [DEV_W-1:0]   heldLow;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sampleDelta <= '0;
      sampleNib   <= '0;
    end else if (ctrl.sampleEn) begin
      sampleDelta <= deltaCut;
      sampleNib   <= devNib;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)               heldLow <= '0;
    else if (ctrl.holdLowEn) heldLow <= sampleNib;
  end

  always_ff @(posedge clk) begin
    if (!rstN)                outData <= '0;
    else if (ctrl.loadRaw)    outData <= BYTE_W'(sampleDelta);
    else if (ctrl.loadPacked) outData <= BYTE_W'({sampleNib, heldLow});
  end

endmodule

// File: rtl/edge_delta_control.sv
module edge_delta_control
  import edge_delta_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  dpStat_t stat,
  input  logic    rawMode,
  input  logic    clrFlags,
  input  logic    outReady,
  output dpCtrl_t ctrl,
  output logic    outValid,
  output logic    overflowFlag,
  output logic    overrunFlag
);

  logic primed;       // a start point has been captured
  logic sampleStb;    // sample stage holds a fresh value
  logic sampleFall;   // that value ended on a falling edge
  logic holdValid;    // low nibble waiting for its partner

  logic takeSample;
  logic wantRaw;
  logic wantPacked;
  logic holdLow;
  logic outFree;
  logic dropNow;
  logic ovfSet;

  assign takeSample = stat.edgeSeen & primed;
  assign ovfSet     = takeSample & (stat.deltaClip | (~rawMode & stat.devClip));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      primed     <= 1'b0;
      sampleStb  <= 1'b0;
      sampleFall <= 1'b0;
    end else begin
      if (stat.edgeSeen) primed <= 1'b1;
      sampleStb  <= takeSample;
      sampleFall <= stat.edgeFall;
    end
  end

  // Decide what the sample stage contributes
  always_comb begin
    wantRaw    = 1'b0;
    wantPacked = 1'b0;
    holdLow    = 1'b0;
    if (sampleStb) begin
      if (rawMode)         wantRaw    = 1'b1;
      else if (sampleFall) holdLow    = 1'b1;
      else if (holdValid)  wantPacked = 1'b1;
    end
  end

  assign outFree = ~outValid | outReady;
  assign dropNow = (wantRaw | wantPacked) & ~outFree;

  assign ctrl.captureEn  = stat.edgeSeen;
  assign ctrl.sampleEn   = takeSample;
  assign ctrl.holdLowEn  = holdLow;
  assign ctrl.loadRaw    = wantRaw & outFree;
  assign ctrl.loadPacked = wantPacked & outFree;

  always_ff @(posedge clk) begin
    if (!rstN)                          holdValid <= 1'b0;
    else if (rawMode)                   holdValid <= 1'b0;
    else if (holdLow)                   holdValid <= 1'b1;
    else if (sampleStb && !sampleFall)  holdValid <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rstN)                                 outValid <= 1'b0;
    else if (ctrl.loadRaw || ctrl.loadPacked)  outValid <= 1'b1;
    else if (outReady)                         outValid <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      overflowFlag <= 1'b0;
      overrunFlag  <= 1'b0;
    end else begin
      if (ovfSet)        overflowFlag <= 1'b1;
      else if (clrFlags) overflowFlag <= 1'b0;
      if (dropNow)       overrunFlag  <= 1'b1;
      else if (clrFlags) overrunFlag  <= 1'b0;
    end
  end

endmodule

// File: rtl/edge_delta_enc.sv
module edge_delta_enc
  import edge_delta_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int DELTA_W     = 6,
  parameter int DEV_W       = 4,
  parameter int BYTE_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [CNT_W-1:0]   fastCount,
  input  logic               refIn,
  input  logic [DELTA_W-1:0] expected,
  input  logic               rawMode,
  input  logic               clrFlags,
  input  logic               outReady,
  output logic [BYTE_W-1:0]  outData,
  output logic               outValid,
  output logic               overflowFlag,
  output logic               overrunFlag
);

  dpCtrl_t ctrl;
  dpStat_t stat;

  edge_delta_datapath #(
    .CNT_W(CNT_W), .DELTA_W(DELTA_W), .DEV_W(DEV_W),
    .BYTE_W(BYTE_W), .SYNC_STAGES(SYNC_STAGES)
  ) uDatapath (
    .clk(clk), .rstN(rstN), .fastCount(fastCount), .refIn(refIn),
    .expected(expected), .ctrl(ctrl), .stat(stat), .outData(outData)
  );

  edge_delta_control uControl (
    .clk(clk), .rstN(rstN), .stat(stat), .rawMode(rawMode),
    .clrFlags(clrFlags), .outReady(outReady), .ctrl(ctrl),
    .outValid(outValid), .overflowFlag(overflowFlag),
    .overrunFlag(overrunFlag)
  );

endmodule

// File: rtl/edge_delta_enc_chk.sv
module edge_delta_enc_chk #(
  parameter int BYTE_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              clrFlags,
  input logic              outReady,
  input logic [BYTE_W-1:0] outData,
  input logic              outValid,
  input logic              overflowFlag,
  input logic              overrunFlag
);

  // R8
  hold_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    outValid && !outReady |=> outValid);

  // R8
  hold_data_chk: assert property (@(posedge clk) disable iff (!rstN)
    outValid && !outReady |=> $stable(outData));

  // R9
  overrun_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(overrunFlag) |-> $past(outValid && !outReady));

  // R9
  overrun_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    overrunFlag && !clrFlags |=> overrunFlag);

  // R6
  overflow_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    overflowFlag && !clrFlags |=> overflowFlag);

  // R10
  overrun_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    clrFlags && !(outValid && !outReady) |=> !overrunFlag);

endmodule

bind edge_delta_enc edge_delta_enc_chk #(.BYTE_W(BYTE_W)) uChk (
  .clk(clk), .rstN(rstN), .clrFlags(clrFlags), .outReady(outReady),
  .outData(outData), .outValid(outValid), .overflowFlag(overflowFlag),
  .overrunFlag(overrunFlag)
);

// File: tb/tb_edge_delta_enc.sv
module tb_edge_delta_enc;

  localparam int CLK_PERIOD = 10;
  localparam int SETTLE     = 8;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] fastCount = '0;
  logic        refIn = 1'b0;
  logic [5:0]  expected = 6'd30;
  logic        rawMode = 1'b0;
  logic        clrFlags = 1'b0;
  logic        outReady = 1'b1;
  logic [7:0]  outData;
  logic        outValid;
  logic        overflowFlag;
  logic        overrunFlag;

  edge_delta_enc dut (
    .clk(clk), .rstN(rstN), .fastCount(fastCount), .refIn(refIn),
    .expected(expected), .rawMode(rawMode), .clrFlags(clrFlags),
    .outReady(outReady), .outData(outData), .outValid(outValid),
    .overflowFlag(overflowFlag), .overrunFlag(overrunFlag)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(negedge clk) fastCount <= fastCount + 16'd1;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  logic [7:0] expQ[$];
  string      tagQ[$];

  // Reference model state
  bit         primedM = 1'b0;
  bit         pendM = 1'b0;
  logic [3:0] lowM = '0;
  bit         heldOut = 1'b0;
  int         elapsed = 0;

  task automatic check(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic pushByte(logic [7:0] b, string tag);
    if (!outReady && heldOut) return;   // R9: consumer full, byte lost
    expQ.push_back(b);
    tagQ.push_back(tag);
    if (!outReady) heldOut = 1'b1;
  endtask

  task automatic model(int n);
    int dev;
    logic [3:0] nib;
    if (!primedM) begin
      primedM = 1'b1;                     // R2: start point only
      return;
    end
    if (rawMode) begin
      pendM = 1'b0;
      pushByte(8'(n > 63 ? 63 : n), n > 63 ? "R4" : "R3");
      return;
    end
    dev = n - int'(expected);
    if (dev > 7) dev = 7;
    if (dev < -8) dev = -8;
    nib = 4'(dev);
    if (refIn == 1'b0) begin
      lowM = nib;
      pendM = 1'b1;
    end else if (pendM) begin
      pushByte({nib, lowM}, "R7");
      pendM = 1'b0;
    end
  endtask

  // One reference half-period of n fast ticks, then let the pipeline settle
  task automatic step(int n);
    repeat (n - SETTLE - elapsed) @(negedge clk);
    refIn = ~refIn;
    model(n);
    repeat (SETTLE) @(negedge clk);
    elapsed = 0;
  endtask

  task automatic pulseClr();
    clrFlags = 1'b1;
    @(negedge clk);
    clrFlags = 1'b0;
    elapsed += 1;
  endtask

  // Scoreboard monitor
  always @(posedge clk) begin
    if (rstN && outValid && outReady) begin
      if (expQ.size() == 0) begin
        check(1'b0, "R2", int'(outData), -1);
      end else begin
        logic [7:0] e;
        string t;
        e = expQ.pop_front();
        t = tagQ.pop_front();
        check(outData == e, t, int'(outData), int'(e));
      end
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    elapsed = 1;
    // R1
    check(outValid == 1'b0, "R1", int'(outValid), 0);
    check(overflowFlag == 1'b0, "R1", int'(overflowFlag), 0);
    check(overrunFlag == 1'b0, "R1", int'(overrunFlag), 0);

    step(12);                    // R2 priming rise
    step(30); step(31);          // R5 R7: 0x10
    step(27); step(35);          // R5: 0x5D
    step(22); step(37);          // R6 boundary: 0x78, no flag
    check(overflowFlag == 1'b0, "R6", int'(overflowFlag), 0);
    step(15); step(50);          // R6 saturation: 0x78
    check(overflowFlag == 1'b1, "R6", int'(overflowFlag), 1);
    pulseClr();
    check(overflowFlag == 1'b0, "R10", int'(overflowFlag), 0);

    expected = 6'd40;
    step(40); step(33);          // R5: 0x90

    // R8 R9: consumer stalls across two periods
    outReady = 1'b0;
    step(40); step(41);          // 0x10 held
    step(39); step(42);          // 0x2F dropped
    check(outValid == 1'b1, "R8", int'(outValid), 1);
    check(outData == 8'h10, "R8", int'(outData), 'h10);
    check(overrunFlag == 1'b1, "R9", int'(overrunFlag), 1);
    outReady = 1'b1;
    heldOut = 1'b0;
    pulseClr();
    check(overrunFlag == 1'b0, "R10", int'(overrunFlag), 0);

    // R3 R4 raw mode
    expected = 6'd30;
    rawMode = 1'b1;
    step(45); step(63);
    check(overflowFlag == 1'b0, "R4", int'(overflowFlag), 0);
    step(70);
    check(overflowFlag == 1'b1, "R4", int'(overflowFlag), 1);
    pulseClr();
    step(20);

    rawMode = 1'b0;
    step(29); step(30);          // 0x0F
    rawMode = 1'b1;
    step(25);                    // raw 0x19 on a fall
    rawMode = 1'b0;
    step(33);                    // R7 orphan rise, discarded
    step(30); step(26);          // 0xC0

    repeat (20) @(negedge clk);
    check(expQ.size() == 0, "R7", expQ.size(), 0);
    check(overrunFlag == 1'b0, "R9", int'(overrunFlag), 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule